// File: doc/BRIEF.md
# Single-Master Handshake Bus Fabric

This fabric connects one processor-side master to a parameterised set of memory-mapped slaves (twelve by default) over 16-bit address and data paths. Every transfer uses a four-phase request/acknowledge handshake on both sides of the fabric, so a slow slave can hold the master for as many cycles as it needs. Write data and read data travel on separate buses. No signal is tristated.

The top byte of the address selects one slave. Slave `i` owns the page value `FIRST_PAGE + i`. The fabric registers that decode into a one-hot select that stays fixed for the whole transfer. Address, write data and the write flag go to every slave unchanged. Read data comes back through a multiplexer steered by the slaves' registered acknowledges, not by the address. An address on a page that no slave owns is served by a built-in responder. It acknowledges with read data of zero, so the master is never left waiting.

Slave acknowledges pass through a register stage inside the fabric. No combinational path therefore runs from the master's request, through the fabric, to any slave's acknowledge or back.

Top module: `hsbus_fabric`

## Requirements
- R1: After reset `m_ack`, `s_req`, every `s_sel` bit and `m_rdata` are all 0.
- R2: `s_addr`, `s_wdata` and `s_we` always equal `m_addr`, `m_wdata` and `m_we`, whether or not a transfer is running.
- R3: A request whose address bits [15:8] equal `FIRST_PAGE + i` (default `FIRST_PAGE` is 8'h10) drives exactly `s_sel[i]` high, together with `s_req`. The select stays constant until the transfer ends.
- R4: A request whose page matches no slave drives no `s_sel` bit. It is acknowledged with `m_rdata` = 0, with the same timing as a zero-wait slave. A write to such a page changes no slave's contents.
- R5: The master is stalled while the selected slave's acknowledge is low. `m_ack` rises exactly four clock edges after `m_req` is first sampled high, plus the number of extra cycles the slave waits before raising `s_ack`. The slave sees `s_req` one edge after the request is taken.
- R6: On a read, `m_rdata` holds the word of the slave whose acknowledge is high. The read buses of slaves that are not acknowledging are ignored.
- R7: While `m_ack` and `m_req` are both high, `s_req` stays high. One edge after the master drops `m_req`, `s_req` is low.
- R8: `m_ack` falls only after the selected slave's acknowledge has fallen. With a slave that drops `s_ack` one edge after `s_req` falls, `m_ack` falls on the fourth edge after `m_req` was dropped.
- R9: A write updates only the addressed slave. A later read of that word returns the written value, and the same word in another slave keeps its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | 1 | Master request, held high until `m_ack` is seen |
| m_we | input | 1 | Master write flag (1 = write) |
| m_addr | input | ADDR_W | Master address; the top PAGE_BITS pick the slave |
| m_wdata | input | DATA_W | Master write data |
| m_ack | output | 1 | Acknowledge to the master |
| m_rdata | output | DATA_W | Read data captured for the master |
| s_req | output | 1 | Request to all slaves, qualified by `s_sel` |
| s_sel | output | NUM_SLV | One-hot slave select |
| s_we | output | 1 | Broadcast write flag |
| s_addr | output | ADDR_W | Broadcast address |
| s_wdata | output | DATA_W | Broadcast write data |
| s_ack | input | NUM_SLV | Per-slave acknowledge |
| s_rdata | input | NUM_SLV*DATA_W | Per-slave read data, slave `i` at bits `i*DATA_W +: DATA_W` |

## Verification
Two events can fall in the same cycle: the end of one handshake (`m_ack` falling) and the start of the next (`m_req` rising). The bench provokes this by raising a new request to a different slave at the very sample point where `m_ack` is first seen low. It then judges the second transfer's select, latency and data exactly as it judges an isolated one. The other overlap is between the selected slave's valid read data and the garbage that every idle slave drives on its own read bus. The bench model drives a distinct non-zero pattern whenever a slave is not acknowledging, so any leak into `m_rdata` shows up as a data mismatch.

// File: rtl/hsbus_pkg.sv
package hsbus_pkg;

   // handshake phases of the fabric towards the master
   typedef enum logic [1:0] {
      HS_IDLE = 2'd0,   // waiting for a request
      HS_REQ  = 2'd1,   // request forwarded, waiting for the slave
      HS_HOLD = 2'd2,   // master acknowledged, waiting for request drop
      HS_REL  = 2'd3    // request withdrawn, waiting for slave release
   } hs_phase_e;

   function automatic logic hs_drives_req(hs_phase_e ph);
      return (ph == HS_REQ) || (ph == HS_HOLD);
   endfunction

endpackage

// File: rtl/hsbus_decode.sv
module hsbus_decode #(
   parameter int NUM_SLV    = 12,
   parameter int PAGE_BITS  = 8,
   parameter int FIRST_PAGE = 16,
   localparam int NT        = NUM_SLV + 1
) (
   input  logic [PAGE_BITS-1:0] page,
   output logic [NT-1:0]        hit
);

   for (genvar i = 0; i < NUM_SLV; i++) begin : g_page
      localparam logic [PAGE_BITS-1:0] PG = PAGE_BITS'(FIRST_PAGE + i);
      assign hit[i] = (page == PG);
   end

   // the spare target catches every unowned page
   assign hit[NT-1] = ~|hit[NUM_SLV-1:0];

endmodule

// File: rtl/hsbus_rdmux.sv
module hsbus_rdmux #(
   parameter int NT     = 13,
   parameter int DATA_W = 16,
   parameter bit AND_OR = 1'b1
) (
   input  logic [NT-1:0]        steer,
   input  logic [NT*DATA_W-1:0] din,
   output logic [DATA_W-1:0]    dout
);

   if (AND_OR) begin : g_andor
      // flat reduction, relies on at most one steer bit being set
      always_comb begin
         dout = '0;
         for (int i = 0; i < NT; i++)
            dout |= din[i*DATA_W +: DATA_W] & {DATA_W{steer[i]}};
      end
   end else begin : g_prio
      // lowest index wins if several steer bits are ever set
      always_comb begin
         dout = '0;
         for (int i = NT - 1; i >= 0; i--)
            if (steer[i]) dout = din[i*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/hsbus_dflt.sv
module hsbus_dflt #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   output logic              ack,
   output logic [DATA_W-1:0] rdata
);

   always_ff @(posedge clk) begin
      if (!rst_n) ack <= 1'b0;
      else        ack <= req;
   end

   assign rdata = '0;

endmodule

// File: rtl/hsbus_ctrl.sv
module hsbus_ctrl
   import hsbus_pkg::*;
#(
   parameter int NT     = 13,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m_req,
   input  logic [NT-1:0]     hit,
   input  logic [NT-1:0]     ack_all,
   input  logic [DATA_W-1:0] mux_data,
   output logic [NT-1:0]     ack_q,
   output logic [NT-1:0]     tgt_sel,
   output logic              fwd_req,
   output logic              m_ack,
   output logic [DATA_W-1:0] m_rdata
);

   hs_phase_e phase;
   logic      tgt_acked;

   assign tgt_acked = |(ack_q & tgt_sel);
   assign fwd_req   = hs_drives_req(phase);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= HS_IDLE;
         ack_q   <= '0;
         tgt_sel <= '0;
         m_ack   <= 1'b0;
         m_rdata <= '0;
      end else begin
         ack_q <= ack_all;
         unique case (phase)
            HS_IDLE: if (m_req) begin
               tgt_sel <= hit;
               phase   <= HS_REQ;
            end
            HS_REQ: if (tgt_acked) begin
               m_ack   <= 1'b1;
               m_rdata <= mux_data;
               phase   <= HS_HOLD;
            end
            HS_HOLD: if (!m_req) phase <= HS_REL;
            HS_REL: if (!tgt_acked) begin
               m_ack   <= 1'b0;
               tgt_sel <= '0;
               phase   <= HS_IDLE;
            end
            default: phase <= HS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/hsbus_fabric.sv
module hsbus_fabric #(
   parameter int NUM_SLV    = 12,
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int PAGE_BITS  = 8,
   parameter int FIRST_PAGE = 16,
   parameter bit AND_OR_MUX = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      m_req,
   input  logic                      m_we,
   input  logic [ADDR_W-1:0]         m_addr,
   input  logic [DATA_W-1:0]         m_wdata,
   output logic                      m_ack,
   output logic [DATA_W-1:0]         m_rdata,
   output logic                      s_req,
   output logic [NUM_SLV-1:0]        s_sel,
   output logic                      s_we,
   output logic [ADDR_W-1:0]         s_addr,
   output logic [DATA_W-1:0]         s_wdata,
   input  logic [NUM_SLV-1:0]        s_ack,
   input  logic [NUM_SLV*DATA_W-1:0] s_rdata
);

   localparam int NT   = NUM_SLV + 1;
   localparam int DFLT = NUM_SLV;

   if (NUM_SLV < 1) begin : g_bad_count
      $error("hsbus_fabric: NUM_SLV must be at least 1");
   end
   if (PAGE_BITS < 1 || PAGE_BITS > ADDR_W) begin : g_bad_page
      $error("hsbus_fabric: PAGE_BITS must lie in 1..ADDR_W");
   end
   if (FIRST_PAGE < 0 || FIRST_PAGE + NUM_SLV > (1 << PAGE_BITS)) begin : g_bad_base
      $error("hsbus_fabric: slave pages do not fit in the page field");
   end

   logic [NT-1:0]        hit;
   logic [NT-1:0]        ack_all;
   logic [NT-1:0]        ack_q;
   logic [NT-1:0]        tgt_sel;
   logic [NT*DATA_W-1:0] rdata_all;
   logic [DATA_W-1:0]    mux_data;
   logic [DATA_W-1:0]    dflt_rdata;
   logic                 dflt_ack;
   logic                 fwd_req;

   // broadcast towards every slave
   assign s_addr  = m_addr;
   assign s_wdata = m_wdata;
   assign s_we    = m_we;
   assign s_req   = fwd_req;
   assign s_sel   = tgt_sel[NUM_SLV-1:0];

   hsbus_decode #(
      .NUM_SLV   (NUM_SLV),
      .PAGE_BITS (PAGE_BITS),
      .FIRST_PAGE(FIRST_PAGE)
   ) u_decode (
      .page(m_addr[ADDR_W-1 -: PAGE_BITS]),
      .hit (hit)
   );

   hsbus_dflt #(.DATA_W(DATA_W)) u_dflt (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (fwd_req & tgt_sel[DFLT]),
      .ack  (dflt_ack),
      .rdata(dflt_rdata)
   );

   assign ack_all   = {dflt_ack, s_ack};
   assign rdata_all = {dflt_rdata, s_rdata};

   hsbus_rdmux #(
      .NT    (NT),
      .DATA_W(DATA_W),
      .AND_OR(AND_OR_MUX)
   ) u_rdmux (
      .steer(ack_q),
      .din  (rdata_all),
      .dout (mux_data)
   );

   hsbus_ctrl #(
      .NT    (NT),
      .DATA_W(DATA_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .m_req   (m_req),
      .hit     (hit),
      .ack_all (ack_all),
      .mux_data(mux_data),
      .ack_q   (ack_q),
      .tgt_sel (tgt_sel),
      .fwd_req (fwd_req),
      .m_ack   (m_ack),
      .m_rdata (m_rdata)
   );

endmodule

// File: rtl/hsbus_fabric_chk.sv
module hsbus_fabric_chk #(
   parameter int NUM_SLV = 12,
   localparam int NT     = NUM_SLV + 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               m_req,
   input logic               m_ack,
   input logic               s_req,
   input logic [NUM_SLV-1:0] s_sel,
   input logic [NT-1:0]      tgt_sel,
   input logic [NT-1:0]      ack_all
);

   logic tgt_ack_raw;
   assign tgt_ack_raw = |(ack_all & tgt_sel);

   // R3: never more than one target chosen
   p_onehot_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tgt_sel));

   // R3: select frozen while the request is forwarded
   p_sel_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (s_req && $past(s_req)) |-> $stable(s_sel));

   // R5: master acknowledge only after the target acknowledged
   p_ack_after_slave_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(m_ack) |-> $past(tgt_ack_raw));

   // R7: request kept towards the slave while the master holds on
   p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (m_ack && m_req) |-> s_req);

   // R7: request withdrawn once the master lets go
   p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (m_ack && !m_req) |=> !s_req);

   // R8: master release only after the target released
   p_ack_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(m_ack) |-> !$past(tgt_ack_raw));

endmodule

bind hsbus_fabric hsbus_fabric_chk #(.NUM_SLV(NUM_SLV)) i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .m_req  (m_req),
   .m_ack  (m_ack),
   .s_req  (s_req),
   .s_sel  (s_sel),
   .tgt_sel(tgt_sel),
   .ack_all(ack_all)
);

// File: tb/test_hsbus_fabric.sv
`timescale 1ns/1ps
module test_hsbus_fabric;

   localparam int NS = 12;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           m_req = 1'b0;
   logic           m_we = 1'b0;
   logic [15:0]    m_addr = '0;
   logic [15:0]    m_wdata = '0;
   logic           m_ack;
   logic [15:0]    m_rdata;
   logic           s_req;
   logic [NS-1:0]  s_sel;
   logic           s_we;
   logic [15:0]    s_addr;
   logic [15:0]    s_wdata;
   logic [NS-1:0]  s_ack;
   logic [NS*16-1:0] s_rdata;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int xtra = 0;

   // slave models
   logic [15:0] mem [NS][4];
   logic [15:0] rd_q [NS];
   int          cnt [NS];

   always #4 clk = ~clk;

   hsbus_fabric i_hsbus_fabric (
      .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
      .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata), .s_req(s_req),
      .s_sel(s_sel), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
      .s_ack(s_ack), .s_rdata(s_rdata)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) begin
            s_ack[i] <= 1'b0;
            cnt[i]   <= 0;
            rd_q[i]  <= '0;
            for (int j = 0; j < 4; j++) mem[i][j] <= 16'(16'hA000 + i*16 + j);
         end
      end else begin
         for (int i = 0; i < NS; i++) begin
            if (s_req && s_sel[i]) begin
               if (!s_ack[i]) begin
                  if (cnt[i] >= (i % 3) + xtra) begin
                     s_ack[i] <= 1'b1;
                     if (s_we) mem[i][s_addr[1:0]] <= s_wdata;
                     else      rd_q[i] <= mem[i][s_addr[1:0]];
                  end else begin
                     cnt[i] <= cnt[i] + 1;
                  end
               end
            end else begin
               s_ack[i] <= 1'b0;
               cnt[i]   <= 0;
            end
         end
      end
   end

   // idle slaves put garbage on their own read bus
   always_comb begin
      for (int i = 0; i < NS; i++)
         s_rdata[i*16 +: 16] = s_ack[i] ? rd_q[i] : 16'(16'h5B00 + i);
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected under 60000", cyc);
         summary();
      end
   end

   // one complete four-phase transfer; checks R7 and R8 itself
   task automatic xfer(input logic [15:0] a, input logic we, input logic [15:0] wd,
                       input int hold, input int slv,
                       output logic [15:0] rd, output int lat, output logic [NS-1:0] sel);
      int n;
      m_addr = a; m_we = we; m_wdata = wd; m_req = 1'b1;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!m_ack && lat < 60);
      rd = m_rdata;
      sel = s_sel;
      chk(s_req == 1'b1, "R7", "s_req at ack", 32'(s_req), 1);
      for (int k = 0; k < hold; k++) begin
         @(negedge clk);
         chk(s_req && m_ack, "R7", "s_req while held", 32'(s_req), 1);
      end
      m_req = 1'b0;
      n = 0;
      @(negedge clk);
      n++;
      chk(s_req == 1'b0, "R7", "s_req after drop", 32'(s_req), 0);
      while (m_ack && n < 60) begin
         if (slv >= 0)
            chk(1'b1, "R8", "slave ack seen while m_ack high", 32'(s_ack[slv]), 32'(s_ack[slv]));
         @(negedge clk);
         n++;
      end
      chk(n == 4, "R8", "edges from drop to m_ack fall", 32'(n), 4);
      if (slv >= 0)
         chk(s_ack[slv] == 1'b0, "R8", "slave ack low at release", 32'(s_ack[slv]), 0);
   endtask

   task automatic t_reset();
      chk(m_ack == 1'b0, "R1", "m_ack", 32'(m_ack), 0);
      chk(s_req == 1'b0, "R1", "s_req", 32'(s_req), 0);
      chk(s_sel == '0, "R1", "s_sel", 32'(s_sel), 0);
      chk(m_rdata == '0, "R1", "m_rdata", 32'(m_rdata), 0);
      m_addr = 16'h13C5; m_wdata = 16'h7E81; m_we = 1'b1;
      @(negedge clk);
      chk(s_addr == 16'h13C5 && s_wdata == 16'h7E81 && s_we,
          "R2", "idle broadcast", {s_addr, s_wdata}, 32'h13C57E81);
      chk(s_req == 1'b0 && m_ack == 1'b0, "R2", "no request without m_req", 32'(s_req), 0);
      m_we = 1'b0;
   endtask

   task automatic t_reads();
      logic [15:0] rd; int lat; logic [NS-1:0] sel;
      for (int i = 0; i < NS; i++) begin
         logic [15:0] a;
         a = {8'(16 + i), 6'd0, 2'(i % 4)};
         xfer(a, 1'b0, 16'h0, 0, i, rd, lat, sel);
         chk(sel == NS'(1 << i), "R3", "one-hot select", 32'(sel), 32'(1 << i));
         chk(lat == 4 + (i % 3), "R5", "read latency", 32'(lat), 32'(4 + i % 3));
         chk(rd == 16'(16'hA000 + i*16 + i % 4), "R6", "read data", 32'(rd),
             32'(16'hA000 + i*16 + i % 4));
      end
   endtask

   task automatic t_stall();
      logic [15:0] rd; int lat; logic [NS-1:0] sel;
      xtra = 6;
      fork
         begin
            xfer(16'h1501, 1'b0, 16'h0, 0, 5, rd, lat, sel);
         end
         begin
            @(negedge clk);
            while (!s_ack[5]) begin
               chk(m_ack == 1'b0, "R5", "master stalled before slave ack", 32'(m_ack), 0);
               chk(s_addr == 16'h1501, "R2", "broadcast during stall", 32'(s_addr), 32'h1501);
               @(negedge clk);
            end
         end
      join
      xtra = 0;
      chk(lat == 4 + 2 + 6, "R5", "stalled latency", 32'(lat), 12);
      chk(rd == 16'hA051, "R6", "stalled read data", 32'(rd), 32'hA051);
   endtask

   task automatic t_write();
      logic [15:0] rd; int lat; logic [NS-1:0] sel;
      xfer(16'h1302, 1'b1, 16'h1234, 0, 3, rd, lat, sel);
      chk(sel == NS'(1 << 3), "R3", "write select", 32'(sel), 32'h8);
      xfer(16'h1302, 1'b0, 16'h0, 0, 3, rd, lat, sel);
      chk(rd == 16'h1234, "R9", "written word read back", 32'(rd), 32'h1234);
      xfer(16'h1402, 1'b0, 16'h0, 0, 4, rd, lat, sel);
      chk(rd == 16'hA042, "R9", "neighbour slave untouched", 32'(rd), 32'hA042);
   endtask

   task automatic t_miss();
      logic [15:0] rd; int lat; logic [NS-1:0] sel;
      logic [7:0] pages [4];
      pages[0] = 8'h00; pages[1] = 8'h0F; pages[2] = 8'h1C; pages[3] = 8'hFF;
      for (int k = 0; k < 4; k++) begin
         xfer({pages[k], 8'h02}, 1'b0, 16'h0, 0, -1, rd, lat, sel);
         chk(sel == '0, "R4", "no select on unowned page", 32'(sel), 0);
         chk(rd == 16'h0, "R4", "zero read data", 32'(rd), 0);
         chk(lat == 4, "R4", "default latency", 32'(lat), 4);
      end
      xfer(16'h1C02, 1'b1, 16'hDEAD, 1, -1, rd, lat, sel);
      xfer(16'h1002, 1'b0, 16'h0, 0, 0, rd, lat, sel);
      chk(rd == 16'hA002, "R4", "miss write left slave 0", 32'(rd), 32'hA002);
      xfer(16'h1B02, 1'b0, 16'h0, 0, 11, rd, lat, sel);
      chk(rd == 16'hA0B2, "R4", "miss write left slave 11", 32'(rd), 32'hA0B2);
   endtask

   task automatic t_hold();
      logic [15:0] rd; int lat; logic [NS-1:0] sel;
      xfer(16'h1703, 1'b0, 16'h0, 3, 7, rd, lat, sel);
      chk(rd == 16'hA073, "R7", "data after long hold", 32'(rd), 32'hA073);
      chk(m_rdata == 16'hA073, "R6", "m_rdata kept after release", 32'(m_rdata), 32'hA073);
   endtask

   task automatic t_b2b();
      logic [15:0] rd; int lat; logic [NS-1:0] sel;
      xfer(16'h1201, 1'b0, 16'h0, 0, 2, rd, lat, sel);
      chk(rd == 16'hA021, "R6", "first of back-to-back", 32'(rd), 32'hA021);
      xfer(16'h1900, 1'b0, 16'h0, 0, 9, rd, lat, sel);
      chk(sel == NS'(1 << 9), "R3", "second back-to-back select", 32'(sel), 32'h200);
      chk(lat == 4, "R5", "second back-to-back latency", 32'(lat), 4);
      chk(rd == 16'hA090, "R6", "second back-to-back data", 32'(rd), 32'hA090);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reads();
      t_stall();
      t_write();
      t_miss();
      t_hold();
      t_b2b();
      repeat (4) @(negedge clk);
      summary();
   end

endmodule